// File: doc/BRIEF.md
# Chroma-from-Luma Luma Subsampler

This block turns the reconstructed luma samples of one transform block into a subsampled luma buffer in Q3 fixed point. That buffer is the input to a chroma-from-luma predictor. Luma arrives as a plain raster stream, one sample per accepted cycle. The block produces one 16-bit result per output position and writes it through a simple buffer write port. Output rows sit at a fixed pitch of 32 entries, whatever the block width.

Each chroma format has its own scale, so all three formats land in the same Q3 range:

- **4:2:0:** a 2x2 neighbourhood sum shifted left by one. The even row of each pair is held in an internal row store, so the stream needs no reordering.
- **4:2:2:** a horizontal pair sum shifted left by two.
- **4:4:4:** the single sample shifted left by three.

Format, width, height and bit depth are captured when a start request is accepted. A one-cycle done pulse closes the block.

Top module: `cfl_luma_subsampler`

## Requirements
- R1: During and straight after reset, `busy_o`, `wr_en_o` and `done_o` are low and `wr_data_o` is zero.
- R2: With format code 2 (4:4:4), each accepted sample at row r, column c gives one write of the sample shifted left by 3, at address r*32+c.
- R3: With format code 1 (4:2:2), columns 2k and 2k+1 of row r give one write of their sum shifted left by 2, at address r*32+k, with one output row per input row.
- R4: With format code 0 (4:2:0), rows 2j and 2j+1 at columns 2k and 2k+1 give one write of the four-sample sum shifted left by 1, at address j*32+k. Even input rows produce no writes, so there are height/2 output rows.
- R5: Format code 3 behaves as 4:4:4. Width and height codes 0,1,2,3 select 4,8,16,32. All of these, and the bit-depth select, are sampled only when a start request is accepted.
- R6: With `hbd_i` low at start, only bits [7:0] of each sample are used.
- R7: With `hbd_i` high at start, all 16 bits of each sample are used, and every result is kept modulo 2^16.
- R8: Output row j always begins at address j*32, also for widths below 32. Entries beyond the output row width are never written.
- R9: `busy_o` rises the cycle after an accepted start. The last write comes the cycle after the last sample is accepted. `done_o` is high for exactly one cycle, the cycle after that last write, and `busy_o` is low in that same cycle.
- R10: A start request while `busy_o` is high is ignored: the running block finishes with its original settings and gives one done pulse.
- R11: Samples offered while idle cause no writes. Cycles with `luma_valid_i` low during a block do not change any result.
- R12: Every written value has its least significant bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for a new block |
| fmt_i | input | 2 | Chroma format: 0 = 4:2:0, 1 = 4:2:2, 2 or 3 = 4:4:4 |
| width_sel_i | input | 2 | Luma width code, width = 4 << code |
| height_sel_i | input | 2 | Luma height code, height = 4 << code |
| hbd_i | input | 1 | High bit-depth select |
| luma_valid_i | input | 1 | Luma sample valid |
| luma_data_i | input | 16 | Luma sample |
| busy_o | output | 1 | Block in progress |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | 10 | Buffer write address, row*32 + column |
| wr_data_o | output | 16 | Q3 subsampled luma value |
| done_o | output | 1 | One-cycle end-of-block pulse |

## Verification
In the middle of a 4:2:0 block, a start request carrying a different format is driven in the same cycle as an accepted luma sample. Sample acceptance and start decode then fall in one cycle. The bench judges the result on the full output buffer, which must match the originally captured format. It also checks the number of writes and requires exactly one done pulse. Separate runs insert idle gaps between samples and offer samples while idle, to show that the counters advance only on accepted samples.

// File: rtl/cfl_sub_pkg.sv
package cfl_sub_pkg;
  typedef enum logic [1:0] {
    FMT_420  = 2'd0,
    FMT_422  = 2'd1,
    FMT_444  = 2'd2,
    FMT_444X = 2'd3
  } fmt_e;

  localparam int unsigned SIZE_BASE = 4;

  function automatic int unsigned size_of_code(input logic [1:0] code);
    return SIZE_BASE << code;
  endfunction
endpackage

// File: rtl/cfl_sub_ctrl.sv
module cfl_sub_ctrl
  import cfl_sub_pkg::*;
#(
  parameter int unsigned MAX_W = 32,
  parameter int unsigned MAX_H = 32,
  localparam int unsigned CW = $clog2(MAX_W),
  localparam int unsigned RW = $clog2(MAX_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    wsel_i,
  input  logic [1:0]    hsel_i,
  input  logic          hbd_i,
  input  logic          valid_i,
  output logic          acc_o,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output fmt_e          fmt_o,
  output logic          hbd_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          busy_q, fin_q, done_q, hbd_q;
  fmt_e          fmt_q;
  logic [CW-1:0] col_q, wlim_q;
  logic [RW-1:0] row_q, hlim_q;
  logic          start_ok, last_col, last_smp;

  assign start_ok = start_i & ~busy_q;
  assign acc_o    = busy_q & valid_i & ~fin_q;
  assign last_col = (col_q == wlim_q);
  assign last_smp = last_col & (row_q == hlim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      hbd_q  <= 1'b0;
      fmt_q  <= FMT_420;
      col_q  <= '0;
      row_q  <= '0;
      wlim_q <= '0;
      hlim_q <= '0;
    end else begin
      fin_q  <= acc_o & last_smp;
      done_q <= fin_q;
      if (start_ok) begin
        busy_q <= 1'b1;
        fmt_q  <= fmt_e'(fmt_i);
        hbd_q  <= hbd_i;
        wlim_q <= CW'(size_of_code(wsel_i) - 1);
        hlim_q <= RW'(size_of_code(hsel_i) - 1);
        col_q  <= '0;
        row_q  <= '0;
      end else if (fin_q) begin
        busy_q <= 1'b0;
      end else if (acc_o) begin
        if (last_col) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign col_o  = col_q;
  assign row_o  = row_q;
  assign fmt_o  = fmt_q;
  assign hbd_o  = hbd_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfl_pair_sum.sv
module cfl_pair_sum #(
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          odd_i,
  input  logic [SW-1:0] smp_i,
  output logic [SW:0]   pair_o
);
  logic [SW-1:0] hold_q;

  // holds the even-column sample until its odd partner arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (acc_i && !odd_i) hold_q <= smp_i;
  end

  assign pair_o = {1'b0, hold_q} + {1'b0, smp_i};
endmodule

// File: rtl/cfl_row_store.sv
module cfl_row_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 17,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ent_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           ent_q <= '0;
      else if (we_i && (waddr_i == IW'(i)))  ent_q <= wdata_i;
    end
    assign ent_w[i] = ent_q;
  end

  assign rdata_o = ent_w[raddr_i];
endmodule

// File: rtl/cfl_luma_subsampler.sv
module cfl_luma_subsampler
  import cfl_sub_pkg::*;
#(
  parameter int unsigned SW    = 16,
  parameter int unsigned OW    = 16,
  parameter int unsigned PITCH = 32,
  parameter int unsigned MAX_W = 32,
  parameter int unsigned MAX_H = 32,
  localparam int unsigned CW   = $clog2(MAX_W),
  localparam int unsigned RW   = $clog2(MAX_H),
  localparam int unsigned AW   = $clog2(PITCH) + RW,
  localparam int unsigned LD   = MAX_W / 2,
  localparam int unsigned LW   = $clog2(LD),
  localparam int unsigned XW   = SW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    width_sel_i,
  input  logic [1:0]    height_sel_i,
  input  logic          hbd_i,
  input  logic          luma_valid_i,
  input  logic [SW-1:0] luma_data_i,
  output logic          busy_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [OW-1:0] wr_data_o,
  output logic          done_o
);
  logic          acc, hbd;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  fmt_e          fmt;
  logic [SW-1:0] smp;
  logic [SW:0]   pair, line_rd;
  logic          is420, is422, is444, emit, line_we;
  logic [RW-1:0] orow;
  logic [CW-1:0] ocol;
  logic [XW-1:0] res;

  cfl_sub_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .fmt_i   (fmt_i),
    .wsel_i  (width_sel_i),
    .hsel_i  (height_sel_i),
    .hbd_i   (hbd_i),
    .valid_i (luma_valid_i),
    .acc_o   (acc),
    .col_o   (col),
    .row_o   (row),
    .fmt_o   (fmt),
    .hbd_o   (hbd),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign smp = hbd ? luma_data_i : {{(SW-8){1'b0}}, luma_data_i[7:0]};

  cfl_pair_sum #(.SW(SW)) u_pair (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .odd_i  (col[0]),
    .smp_i  (smp),
    .pair_o (pair)
  );

  assign is420   = (fmt == FMT_420);
  assign is422   = (fmt == FMT_422);
  assign is444   = fmt[1];
  assign line_we = acc & is420 & ~row[0] & col[0];

  cfl_row_store #(.DEPTH(LD), .DW(SW+1)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (line_we),
    .waddr_i (LW'(col >> 1)),
    .wdata_i (pair),
    .raddr_i (LW'(col >> 1)),
    .rdata_o (line_rd)
  );

  assign emit = acc & (is444 | (col[0] & (is422 | row[0])));
  assign orow = is420 ? (row >> 1) : row;
  assign ocol = is444 ? col : (col >> 1);

  always_comb begin
    if (is444)      res = XW'(smp) << 3;
    else if (is422) res = XW'(pair) << 2;
    else            res = XW'({1'b0, pair} + {1'b0, line_rd}) << 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= emit;
      if (emit) begin
        wr_addr_o <= AW'(orow) * AW'(PITCH) + AW'(ocol);
        wr_data_o <= OW'(res);
      end
    end
  end
endmodule

// File: rtl/cfl_luma_subsampler_chk.sv
module cfl_luma_subsampler_chk #(
  parameter int unsigned OW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          wr_en_o,
  input logic [OW-1:0] wr_data_o,
  input logic          done_o
);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(wr_en_o) && !busy_o));
  p_busy_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  p_idle_no_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_en_o);
  p_even_data_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !wr_data_o[0]);
endmodule

bind cfl_luma_subsampler cfl_luma_subsampler_chk #(.OW(OW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .wr_en_o   (wr_en_o),
  .wr_data_o (wr_data_o),
  .done_o    (done_o)
);

// File: tb/cfl_luma_subsampler_tb_top.sv
`timescale 1ns/1ps
module cfl_luma_subsampler_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic [1:0]  width_sel_i = 2'd0;
  logic [1:0]  height_sel_i = 2'd0;
  logic        hbd_i = 1'b0;
  logic        luma_valid_i = 1'b0;
  logic [15:0] luma_data_i = 16'd0;
  logic        busy_o, wr_en_o, done_o;
  logic [9:0]  wr_addr_o;
  logic [15:0] wr_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt, done_cnt, done_bad, odd_cnt;
  bit prev_wr = 1'b0;
  logic [15:0] mem [1024];

  always #2.5 clk_i = ~clk_i;

  cfl_luma_subsampler dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .fmt_i        (fmt_i),
    .width_sel_i  (width_sel_i),
    .height_sel_i (height_sel_i),
    .hbd_i        (hbd_i),
    .luma_valid_i (luma_valid_i),
    .luma_data_i  (luma_data_i),
    .busy_o       (busy_o),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .done_o       (done_o)
  );

  always @(negedge clk_i) begin
    if (wr_en_o) begin
      mem[wr_addr_o] = wr_data_o;
      wr_cnt++;
      if (wr_data_o[0]) odd_cnt++;
    end
    if (done_o) begin
      done_cnt++;
      if (!prev_wr || busy_o) done_bad++;
    end
    prev_wr = wr_en_o;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] raw(input int r, input int c, input int seed);
    return 16'((seed * 4099) ^ (r * 97 + c * 13 + seed * 29));
  endfunction

  function automatic int smp(input int r, input int c, input int seed, input int hbd);
    logic [15:0] v = raw(r, c, seed);
    return hbd ? int'(v) : int'(v[7:0]);
  endfunction

  function automatic logic [15:0] exp_out(input int fmt, input int r, input int c,
                                          input int seed, input int hbd);
    int s;
    if (fmt >= 2) s = smp(r, c, seed, hbd) * 8;
    else if (fmt == 1) s = (smp(r, 2*c, seed, hbd) + smp(r, 2*c+1, seed, hbd)) * 4;
    else s = (smp(2*r, 2*c, seed, hbd) + smp(2*r, 2*c+1, seed, hbd) +
              smp(2*r+1, 2*c, seed, hbd) + smp(2*r+1, 2*c+1, seed, hbd)) * 2;
    return 16'(s);
  endfunction

  task automatic run_block(input int fmt, input int wc, input int hc, input int hbd,
                           input int seed, input bit gap, input bit mid_start,
                           input string tag);
    int w = 4 << wc;
    int h = 4 << hc;
    int ow = (fmt < 2) ? w / 2 : w;
    int oh = (fmt == 0) ? h / 2 : h;
    int alt = (fmt + 1) % 3;
    int bad = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'hFFFF;
    wr_cnt = 0; done_cnt = 0; done_bad = 0; odd_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b1; fmt_i = 2'(fmt); width_sel_i = 2'(wc); height_sel_i = 2'(hc);
    hbd_i = 1'(hbd);
    @(negedge clk_i);
    start_i = 1'b0; fmt_i = 2'(alt); width_sel_i = 2'(wc ^ 1); hbd_i = ~1'(hbd);
    check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        if (gap && ((r + c) % 3 == 0)) begin
          luma_valid_i = 1'b0;
          luma_data_i = 16'h5555;
          @(negedge clk_i);
        end
        luma_valid_i = 1'b1;
        luma_data_i = raw(r, c, seed);
        start_i = (mid_start && r == 1 && c == 0);
        @(negedge clk_i);
        start_i = 1'b0;
      end
    end
    luma_valid_i = 1'b0;
    for (int k = 0; k < 20 && done_cnt == 0; k++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    check(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    check(done_bad == 0, "R9 done after last write, idle", done_bad, 0);
    check(busy_o == 1'b0, "R9 idle after done", busy_o, 0);
    check(wr_cnt == ow * oh, {tag, " write count"}, wr_cnt, ow * oh);
    check(odd_cnt == 0, "R12 odd values written", odd_cnt, 0);
    for (int r = 0; r < oh; r++)
      for (int c = 0; c < ow; c++)
        if (mem[r*32+c] !== exp_out(fmt, r, c, seed, hbd)) begin
          if (bad == 0)
            check(1'b0, {tag, " value"}, mem[r*32+c], exp_out(fmt, r, c, seed, hbd));
          bad++;
        end
    check(bad == 0, {tag, " mismatching entries"}, bad, 0);
    for (int r = 0; r < oh; r++)
      for (int c = ow; c < 32; c++)
        if (mem[r*32+c] !== 16'hFFFF) bad++;
    check(bad == 0, "R8 entries beyond row width untouched", bad, 0);
  endtask

  task automatic t_reset();
    check(busy_o == 0 && wr_en_o == 0 && done_o == 0, "R1 control outputs in reset",
          {busy_o, wr_en_o, done_o}, 0);
    check(wr_data_o == 0, "R1 data in reset", wr_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 0 && wr_en_o == 0 && done_o == 0, "R1 control after reset",
          {busy_o, wr_en_o, done_o}, 0);
  endtask

  task automatic t_fmt444();  run_block(2, 1, 0, 0, 3, 0, 0, "R2"); endtask
  task automatic t_fmt422();  run_block(1, 2, 1, 0, 5, 0, 0, "R3"); endtask
  task automatic t_fmt420();  run_block(0, 3, 2, 0, 7, 0, 0, "R4"); endtask
  task automatic t_code3();   run_block(3, 0, 0, 0, 9, 0, 0, "R5"); endtask
  task automatic t_lbd_mask(); run_block(0, 1, 1, 0, 11, 0, 0, "R6"); endtask

  task automatic t_hbd();
    run_block(1, 1, 0, 1, 13, 0, 0, "R7");
    run_block(2, 2, 0, 1, 15, 0, 0, "R7");
    run_block(0, 2, 1, 1, 17, 0, 0, "R7");
  endtask

  task automatic t_pitch();
    run_block(0, 0, 1, 0, 19, 0, 0, "R8");
    check(mem[96] == exp_out(0, 3, 0, 19, 0), "R8 row 3 at address 96", mem[96],
          exp_out(0, 3, 0, 19, 0));
    check(mem[2] === 16'hFFFF, "R8 address 2 not written", mem[2], 16'hFFFF);
  endtask

  task automatic t_busy_start(); run_block(0, 2, 1, 0, 21, 0, 1, "R10"); endtask

  task automatic t_idle_valid();
    wr_cnt = 0;
    for (int k = 0; k < 8; k++) begin
      luma_valid_i = 1'b1;
      luma_data_i = 16'(k * 17 + 1);
      @(negedge clk_i);
    end
    luma_valid_i = 1'b0;
    @(negedge clk_i);
    check(wr_cnt == 0, "R11 no writes while idle", wr_cnt, 0);
    check(busy_o == 1'b0, "R11 still idle", busy_o, 0);
    run_block(0, 1, 1, 0, 23, 1, 0, "R11");
    run_block(1, 3, 0, 0, 25, 1, 0, "R11");
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_fmt444();
    t_fmt422();
    t_fmt420();
    t_code3();
    t_lbd_mask();
    t_hbd();
    t_pitch();
    t_busy_start();
    t_idle_valid();
    repeat (4) @(negedge clk_i);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule